// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two W-bit buses, A and B. Each bus owns a storage register that loads on the rising edge of a capture strobe for that bus. Output enable and direction decide whether neither bus, the A bus or the B bus is driven. A select for each direction decides whether the driven bus carries live data from the other bus or the word held in the other bus's register. A parameter picks a plain or a complemented data path.

The pads are split into an input, an output and an output-enable port for each bus, so the block synthesizes and the pad ring supplies the tri-state drivers. The capture strobes are ordinary signals sampled in the one system clock domain. A register loads when its strobe is seen high after being seen low.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When `cap_a` is sampled high at a clock edge after being sampled low at the edge before, the A store loads `a_in` as sampled at that edge. The new value is visible after that edge.
- R2: When `cap_b` is sampled high at a clock edge after being sampled low at the edge before, the B store loads `b_in` as sampled at that edge.
- R3: Loading of either store does not depend on `oe_n`, `dir` or the selects. A bus that is being driven may store any value.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both 0.
- R5: While `oe_n` is 0 and reset is released, `dir`=0 gives `a_oe`=1 and `b_oe`=0, and `dir`=1 gives `b_oe`=1 and `a_oe`=0.
- R6: `a_oe` and `b_oe` are never 1 together.
- R7: `b_out` carries live `a_in` when `sel_ab`=0 and the A store when `sel_ab`=1. `a_out` carries live `b_in` when `sel_ba`=0 and the B store when `sel_ba`=1. This holds whatever the enables are.
- R8: With INVERT=1, every bit of `a_out` and `b_out` is the complement of the value that R7 selects. With INVERT=0, the value passes through unchanged.
- R9: While `rst_n` is 0, both enables are 0. A synchronous reset clears both stores to zero.
- R10: A strobe that stays high loads only once. Later changes on the bus are not stored until the strobe has gone low and risen again.
- R11: A change on a select, on live bus data or on `oe_n`/`dir` reaches the outputs in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Active-low output enable for the transceiver |
| dir | input | 1 | 0: drive the A bus, 1: drive the B bus |
| sel_ab | input | 1 | Source for B bus: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A bus: 0 live B, 1 stored B |
| cap_a | input | 1 | A store capture strobe (rising edge) |
| cap_b | input | 1 | B store capture strobe (rising edge) |
| a_in | input | WIDTH | A pad input value |
| a_out | output | WIDTH | A pad output value |
| a_oe | output | 1 | A pad output enable |
| b_in | input | WIDTH | B pad input value |
| b_out | output | WIDTH | B pad output value |
| b_oe | output | 1 | B pad output enable |

## Verification
The hardest case to reach is a strobe held high across several edges while its bus keeps changing. From the ports, a second load looks just like the first unless the stored word can be told apart from the live data. The bench parks a strobe high, changes the bus, and then reads the store back through the stored path, with the live data set to a different value. It also loads each store while the block is isolated and while the other bus is driven. This shows that loading ignores the enables.

// File: rtl/bus_xcvr_pkg.sv
// Package: shared types for the registered bus transceiver.
// Assumes: nothing beyond the includer using the drive-mode enum.
package bus_xcvr_pkg;

    // Which side of the transceiver owns its pads.
    typedef enum logic [1:0] {
        DRV_IDLE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drv_mode_e;

endpackage

// File: rtl/bus_xcvr_capture.sv
// Module: capture store for one bus.
// Loads the bus word when the strobe is seen high after being seen low.
// Assumes: the strobe is already synchronous to clk. Reset is synchronous, active low.
module bus_xcvr_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] held
);

    logic strobe_q;
    logic load;

    // Rising edge of the strobe, as seen at consecutive clock edges.
    assign load = strobe && !strobe_q;

    // Remember the strobe level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Store the bus word on a detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= bus_in;
    end

endmodule

// File: rtl/bus_xcvr_path.sv
// Module: one direction's output data path.
// Picks live or stored data, then complements it if INVERT is set.
// Assumes: purely combinational; the caller handles the enables.
module bus_xcvr_path #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             use_store,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] data_out
);

    logic [WIDTH-1:0] picked;

    // Choose the live word or the stored word.
    always_comb picked = use_store ? stored : live;

    // Polarity variant chosen at elaboration.
    generate
        if (INVERT) begin : g_inv
            assign data_out = ~picked;
        end else begin : g_pass
            assign data_out = picked;
        end
    endgenerate

endmodule

// File: rtl/bus_xcvr_drive.sv
// Module: decides which bus, if any, is driven.
// Assumes: oe_n is active low; both enables are held low while in reset.
module bus_xcvr_drive
    import bus_xcvr_pkg::*;
(
    input  logic rst_n,
    input  logic oe_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);

    drv_mode_e mode;

    // Decode the enable and direction into one owner.
    always_comb begin
        if (!rst_n || oe_n) mode = DRV_IDLE;
        else if (dir)       mode = DRV_B;
        else                mode = DRV_A;
    end

    // Each enable is tied to a single enum value, so only one can be high.
    assign a_oe = (mode == DRV_A);
    assign b_oe = (mode == DRV_B);

endmodule

// File: rtl/bus_xcvr_reg.sv
// Module: registered bidirectional bus transceiver (top).
// Two capture stores, two selectable output paths and one drive decoder.
// Assumes: the pads are split into in/out/oe; the strobes are in the clk domain.
module bus_xcvr_reg #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    logic [WIDTH-1:0] store_a;
    logic [WIDTH-1:0] store_b;

    // A-side store; its strobe is never gated by the enables.
    bus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .strobe(cap_a), .bus_in(a_in), .held(store_a)
    );

    // B-side store.
    bus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .strobe(cap_b), .bus_in(b_in), .held(store_b)
    );

    // Data headed for the B pads.
    bus_xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ab (
        .use_store(sel_ab), .live(a_in), .stored(store_a), .data_out(b_out)
    );

    // Data headed for the A pads.
    bus_xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ba (
        .use_store(sel_ba), .live(b_in), .stored(store_b), .data_out(a_out)
    );

    // Pad ownership.
    bus_xcvr_drive u_drive (
        .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
    );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
// Module: assertion checker bound to bus_xcvr_reg.
// Keeps its own copy of each store, built from the strobes seen at the ports.
module bus_xcvr_reg_chk #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic             cap_a,
    input logic             cap_b,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe
);

    logic [WIDTH-1:0] shad_a, shad_b;
    logic             ca_q, cb_q;

    function automatic logic [WIDTH-1:0] fx(input logic [WIDTH-1:0] v);
        return INVERT ? ~v : v;
    endfunction

    // Shadow stores, loaded from the strobe edges seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shad_a <= '0; shad_b <= '0; ca_q <= 1'b0; cb_q <= 1'b0;
        end else begin
            ca_q <= cap_a;
            cb_q <= cap_b;
            if (cap_a && !ca_q) shad_a <= a_in;
            if (cap_b && !cb_q) shad_b <= b_in;
        end
    end

    AST_STORE_A: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ab |-> b_out == fx(shad_a));                                  // R1
    AST_STORE_B: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ba |-> a_out == fx(shad_b));                                  // R2
    AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));                                       // R4
    AST_DIR_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (a_oe == !dir && b_oe == dir));                         // R5
    AST_ONE_DRIVER: assert property (@(posedge clk)
        !(a_oe && b_oe));                                                 // R6
    AST_LIVE_AB: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ab |-> b_out == fx(a_in));                                   // R7
    AST_LIVE_BA: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ba |-> a_out == fx(b_in));                                   // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!a_oe && !b_oe));                                     // R9

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n, oe_n, dir, sel_ab, sel_ba, cap_a, cap_b;
    logic [W-1:0] a_in, b_in, a_out, b_out, a_out_i, b_out_i;
    logic a_oe, b_oe, a_oe_i, b_oe_i;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
        .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .a_out(a_out),
        .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

    bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u_dut_inv (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
        .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .a_out(a_out_i),
        .a_oe(a_oe_i), .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i));

    // Row: {oe_n, dir, sel_ab, sel_ba, a_in, b_in, a_oe, b_oe, a_out, b_out}
    // Stores preloaded with A = 3C, B = A5.
    localparam logic [37:0] VEC [0:5] = '{
        {4'b1000, 8'h11, 8'h22, 2'b00, 8'h22, 8'h11},
        {4'b0000, 8'h77, 8'h5A, 2'b10, 8'h5A, 8'h77},
        {4'b0001, 8'h77, 8'h5A, 2'b10, 8'hA5, 8'h77},
        {4'b0100, 8'hF0, 8'h0F, 2'b01, 8'h0F, 8'hF0},
        {4'b0110, 8'hF0, 8'h0F, 2'b01, 8'h0F, 8'h3C},
        {4'b1111, 8'h81, 8'h18, 2'b00, 8'hA5, 8'h3C}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Load the A store with v: strobe rises before the next edge, then falls.
    task automatic load_a(input logic [W-1:0] v);
        @(negedge clk); a_in = v; cap_a = 1'b1;
        @(negedge clk); cap_a = 1'b0;
    endtask

    task automatic load_b(input logic [W-1:0] v);
        @(negedge clk); b_in = v; cap_b = 1'b1;
        @(negedge clk); cap_b = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; dir = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
        cap_a = 1'b0; cap_b = 1'b0; a_in = 8'hEE; b_in = 8'hDD;
        repeat (3) @(negedge clk);
        #1;
        // R9: enables held low in reset even though oe_n=0
        chk("R9 a_oe in reset", {7'd0, a_oe}, 8'd0);
        dir = 1'b1; #1;
        chk("R9 b_oe in reset", {7'd0, b_oe}, 8'd0);
        @(negedge clk); rst_n = 1'b1; #1;
        // R9: stores cleared, read through stored paths
        chk("R9 store A cleared", b_out, 8'h00);
        chk("R9 store B cleared", a_out, 8'h00);

        // R3: load A while B is driven, load B while isolated
        oe_n = 1'b0; dir = 1'b1;
        load_a(8'h3C); #1;
        a_in = 8'h99; #1;
        chk("R1 R3 A stored while B driven", b_out, 8'h3C);
        oe_n = 1'b1;
        load_b(8'hA5); #1;
        b_in = 8'h66; #1;
        chk("R2 R3 B stored while isolated", a_out, 8'hA5);

        // Table walk: R4 R5 R6 R7 R8 R11, with the strobes idle
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            {oe_n, dir, sel_ab, sel_ba} = VEC[i][37:34];
            a_in = VEC[i][33:26];
            b_in = VEC[i][25:18];
            #1;
            chk($sformatf("R4 R5 R6 row%0d enables", i), {6'd0, a_oe, b_oe}, {6'd0, VEC[i][17:16]});
            chk($sformatf("R7 R11 row%0d a_out", i), a_out, VEC[i][15:8]);
            chk($sformatf("R7 R11 row%0d b_out", i), b_out, VEC[i][7:0]);
            chk($sformatf("R8 row%0d a_out inv", i), a_out_i, ~VEC[i][15:8]);
            chk($sformatf("R8 row%0d b_out inv", i), b_out_i, ~VEC[i][7:0]);
        end

        // R10: a strobe held high loads once only
        sel_ab = 1'b1;
        @(negedge clk); a_in = 8'h42; cap_a = 1'b1;
        @(negedge clk); a_in = 8'hBD;
        @(negedge clk); a_in = 8'h07;
        @(negedge clk); #1;
        chk("R10 held strobe loads once", b_out, 8'h42);
        cap_a = 1'b0;
        @(negedge clk); cap_a = 1'b1;
        @(negedge clk); cap_a = 1'b0; a_in = 8'h00; #1;
        chk("R10 R1 re-armed strobe loads", b_out, 8'h07);

        // R2 R3: B loaded while A is being driven from live B
        oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b0;
        load_b(8'hC3); #1;
        chk("R7 live B to A", a_out, 8'hC3);
        b_in = 8'h12; sel_ba = 1'b1; #1;
        chk("R2 R11 stored B after select flip", a_out, 8'hC3);
        chk("R8 stored B inverted", a_out_i, 8'h3C);

        // R9: a second reset clears both stores
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R9 store A cleared again", b_out, 8'h00);
        chk("R9 store B cleared again", a_out, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule